// File: doc/BRIEF.md
# Quasi-Resonant Gate Turn-Off Controller

This block holds the gate-drive state of a switching power converter. A turn-on request, which would come from a valley or zero-crossing detector outside the block, sets the gate high. Several things can end the pulse, and the block records which one did. The feedback compare input ends the pulse when the scaled current-sense level rises past the regulation level. A programmable on-time budget can run out. The cycle-by-cycle current-limit compare input can also end it, but it is masked for a programmable blanking window after each turn-on.

A separate short-circuit compare input guards against shorted windings or a shorted output diode. It passes through a spike filter: it must stay asserted for a programmable number of consecutive cycles. When that happens, the block shuts the gate down and stays shut down until reset. All comparators and the valley detector are outside the block, so every input is a synchronous digital level. All times are counted in system clock cycles.

Top module: `qrg_gate_ctrl`

## Requirements
- R1: After synchronous active-low reset, gate_o is 0, latched_o is 0 and off_cause_o is 0.
- R2: When gate_o is 0, latched_o is 0 and turn_on_req_i is 1 (and no short-circuit trip fires in that cycle), gate_o is 1 after the next clock edge. A request while gate_o is 1 has no effect.
- R3: While gate_o is 1, fb_trip_i = 1 makes gate_o 0 after the next edge, with off_cause_o = 0 (feedback).
- R4: Without any other turn-off, gate_o stays 1 for exactly max(ton_max_i, 1) cycles, and then off_cause_o = 1 (on-time).
- R5: Number the high cycles from k = 0, the first cycle after turn-on. If ilim_trip_i = 1 in a cycle with k >= leb_len_i, gate_o is 0 after the next edge, with off_cause_o = 2 (current limit).
- R6: ilim_trip_i is ignored in the high cycles with k < leb_len_i. The blanking window starts again at every turn-on.
- R7: If short_trip_i is 1 for max(ssw_len_i, 1) consecutive cycles, then at the edge that ends the last of those cycles latched_o becomes 1, gate_o becomes 0 and off_cause_o becomes 3 (latch-off).
- R8: A short_trip_i pulse shorter than the filter length clears the count and does not latch. A later pulse needs the full length again.
- R9: While latched_o is 1, gate_o stays 0 and turn_on_req_i is ignored, until reset.
- R10: When several turn-off causes occur in one cycle, off_cause_o reports the highest: latch-off, then current limit, then on-time, then feedback.
- R11: If a turn-off cause and turn_on_req_i are both present while gate_o is 1, gate_o goes to 0. A request that is still present in the following cycle turns the gate on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| turn_on_req_i | input | 1 | Turn-on request from the valley detector |
| fb_trip_i | input | 1 | Feedback compare: sense level above regulation level |
| ilim_trip_i | input | 1 | Cycle-by-cycle current-limit compare |
| short_trip_i | input | 1 | Short-circuit compare (higher threshold) |
| ton_max_i | input | ONT_W | Maximum on-time in cycles |
| leb_len_i | input | BLK_W | Leading-edge blanking length in cycles |
| ssw_len_i | input | BLK_W | Short-circuit spike filter length in cycles |
| gate_o | output | 1 | Gate drive |
| latched_o | output | 1 | Latched shutdown active |
| off_cause_o | output | 2 | Cause of the latest turn-off (0 feedback, 1 on-time, 2 current limit, 3 latch-off) |

## Verification
The bench builds the block with the default widths: a 16-bit on-time counter and 8-bit blanking counters. It sets the run-time lengths small (on-time 20, 3 and 0; blanking 5 and 0; spike filter 4). With those values, every timeout, blanking edge and filter boundary falls within a few dozen cycles. The zero settings exercise the clamp to one cycle for on-time and the no-blanking case for the current limit. Equal-cycle collisions among turn-off causes check the priority order.

// File: rtl/qrg_pkg.sv
package qrg_pkg;

    typedef enum logic [1:0] {
        OFF_FB    = 2'd0,
        OFF_TON   = 2'd1,
        OFF_ILIM  = 2'd2,
        OFF_LATCH = 2'd3
    } off_cause_e;

    typedef struct packed {
        logic       gate;
        logic       latch;
        off_cause_e cause;
    } ctl_state_t;

endpackage

// File: rtl/qrg_cycle_timer.sv
// Saturating cycle counter with two hit flavours chosen by LOOKAHEAD:
//   LOOKAHEAD=1 : hit_o when this counted cycle completes len_i cycles
//   LOOKAHEAD=0 : hit_o once len_i cycles have already been counted
module qrg_cycle_timer #(
    parameter int W         = 8,
    parameter bit LOOKAHEAD = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] len_i,
    output logic         hit_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q, cnt_d;
    logic [W:0]   cnt_plus;

    assign cnt_plus = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_plus[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (LOOKAHEAD) begin : g_look
            assign hit_o = inc_i && (cnt_plus >= {1'b0, len_i});
        end else begin : g_past
            assign hit_o = (cnt_q >= len_i);
        end
    endgenerate

    // Saturation: a full counter never wraps back unless cleared (R4, R6, R8)
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

    // A clear always brings the count back to zero (R8)
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/qrg_gate_ctrl.sv
module qrg_gate_ctrl
    import qrg_pkg::*;
#(
    parameter int ONT_W = 16,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             turn_on_req_i,
    input  logic             fb_trip_i,
    input  logic             ilim_trip_i,
    input  logic             short_trip_i,
    input  logic [ONT_W-1:0] ton_max_i,
    input  logic [BLK_W-1:0] leb_len_i,
    input  logic [BLK_W-1:0] ssw_len_i,
    output logic             gate_o,
    output logic             latched_o,
    output logic [1:0]       off_cause_o
);

    ctl_state_t st_q, st_d;

    logic start_on;
    logic ton_hit;
    logic leb_open;
    logic short_fire;
    logic ilim_off;

    assign start_on = !st_q.gate && !st_q.latch && turn_on_req_i && !short_fire;
    assign ilim_off = st_q.gate && ilim_trip_i && leb_open;

    // On-time budget: counts high cycles, fires on the last allowed one
    qrg_cycle_timer #(.W(ONT_W), .LOOKAHEAD(1'b1)) u_ton (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_on),
        .inc_i (st_q.gate),
        .len_i (ton_max_i),
        .hit_o (ton_hit)
    );

    // Leading-edge blanking: current limit is seen once blanking has elapsed
    qrg_cycle_timer #(.W(BLK_W), .LOOKAHEAD(1'b0)) u_leb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_on),
        .inc_i (st_q.gate),
        .len_i (leb_len_i),
        .hit_o (leb_open)
    );

    // Short-circuit spike filter: consecutive active cycles only
    qrg_cycle_timer #(.W(BLK_W), .LOOKAHEAD(1'b1)) u_ssw (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (!short_trip_i),
        .inc_i (short_trip_i),
        .len_i (ssw_len_i),
        .hit_o (short_fire)
    );

    always_comb begin
        st_d = st_q;
        if (short_fire) begin
            st_d.latch = 1'b1;
            st_d.gate  = 1'b0;
            st_d.cause = OFF_LATCH;
        end else if (st_q.gate) begin
            if (ilim_off) begin
                st_d.gate  = 1'b0;
                st_d.cause = OFF_ILIM;
            end else if (ton_hit) begin
                st_d.gate  = 1'b0;
                st_d.cause = OFF_TON;
            end else if (fb_trip_i) begin
                st_d.gate  = 1'b0;
                st_d.cause = OFF_FB;
            end
        end else if (start_on) begin
            st_d.gate = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gate  <= 1'b0;
            st_q.latch <= 1'b0;
            st_q.cause <= OFF_FB;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o      = st_q.gate;
    assign latched_o   = st_q.latch;
    assign off_cause_o = st_q.cause;

    // R9: latched shutdown keeps the gate low and is sticky
    assert_latch_gate_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.latch |-> !st_q.gate);
    assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.latch |=> st_q.latch);

    // R3: feedback trip while high ends the pulse at the next edge
    assert_fb_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gate && fb_trip_i) |=> !st_q.gate);

    // R5: unblanked current limit ends the pulse at the next edge
    assert_ilim_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gate && ilim_trip_i && leb_open) |=> (!st_q.gate && st_q.cause != OFF_FB));

    // R4: on-time expiry ends the pulse at the next edge
    assert_ton_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gate && ton_hit) |=> !st_q.gate);

    // R2: an accepted request raises the gate at the next edge
    assert_turn_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.gate && !st_q.latch && turn_on_req_i && !short_fire) |=> st_q.gate);

    // R7: a completed filter window latches at the next edge
    assert_short_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        short_fire |=> (st_q.latch && st_q.cause == OFF_LATCH));

endmodule

// File: tb/qrg_gate_ctrl_tb_top.sv
module qrg_gate_ctrl_tb_top;

    localparam int ONT_W = 16;
    localparam int BLK_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             on_req = 1'b0;
    logic             fb = 1'b0;
    logic             ilim = 1'b0;
    logic             shrt = 1'b0;
    logic [ONT_W-1:0] ton_max = 16'd20;
    logic [BLK_W-1:0] leb_len = 8'd5;
    logic [BLK_W-1:0] ssw_len = 8'd4;
    logic             gate;
    logic             latched;
    logic [1:0]       cause;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    qrg_gate_ctrl #(.ONT_W(ONT_W), .BLK_W(BLK_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .turn_on_req_i (on_req),
        .fb_trip_i     (fb),
        .ilim_trip_i   (ilim),
        .short_trip_i  (shrt),
        .ton_max_i     (ton_max),
        .leb_len_i     (leb_len),
        .ssw_len_i     (ssw_len),
        .gate_o        (gate),
        .latched_o     (latched),
        .off_cause_o   (cause)
    );

    // advance one edge; inputs and samples live 1 ns after the edge
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; on_req = 0; fb = 0; ilim = 0; shrt = 0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse_on();
        on_req = 1'b1;
        tick();
        on_req = 1'b0;
    endtask

    // counts high samples starting with the current one, until gate falls
    task automatic count_high(output int n);
        n = 0;
        while (gate && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 gate after reset", gate, 0);
        check("R1 latched after reset", latched, 0);
        check("R1 cause after reset", cause, 0);
    endtask

    task automatic t_on_fb();
        ton_max = 16'd500;
        pulse_on();
        check("R2 gate rises", gate, 1);
        on_req = 1'b1;
        tick(3);
        check("R2 request while high no effect", gate, 1);
        on_req = 1'b0;
        fb = 1'b1;
        tick();
        fb = 1'b0;
        check("R3 feedback turns off", gate, 0);
        check("R3 cause feedback", cause, 0);
        // R11: off and request together while high
        pulse_on();
        check("R11 gate high", gate, 1);
        fb = 1'b1; on_req = 1'b1;
        tick();
        fb = 1'b0;
        check("R11 off wins over request", gate, 0);
        tick();
        on_req = 1'b0;
        check("R11 request next cycle turns on", gate, 1);
        fb = 1'b1;
        tick();
        fb = 1'b0;
    endtask

    task automatic t_ontime();
        int n;
        ton_max = 16'd20;
        pulse_on();
        count_high(n);
        check("R4 high cycles for 20", n, 20);
        check("R4 cause on-time", cause, 1);
        ton_max = 16'd0;
        pulse_on();
        count_high(n);
        check("R4 high cycles for 0 clamps to 1", n, 1);
        ton_max = 16'd500;
    endtask

    task automatic t_ilim();
        int n;
        leb_len = 8'd5;
        ilim = 1'b1;
        pulse_on();
        count_high(n);
        check("R6 blanking holds 5 cycles then R5 trips", n, 6);
        check("R5 cause current limit", cause, 2);
        pulse_on();
        count_high(n);
        check("R6 blanking restarts on new turn-on", n, 6);
        leb_len = 8'd0;
        pulse_on();
        count_high(n);
        check("R5 no blanking trips at once", n, 1);
        ilim = 1'b0;
    endtask

    task automatic t_priority();
        int n;
        leb_len = 8'd0;
        ton_max = 16'd500;
        pulse_on();
        fb = 1'b1; ilim = 1'b1;
        tick();
        fb = 1'b0; ilim = 1'b0;
        check("R10 ilim over feedback gate", gate, 0);
        check("R10 ilim over feedback cause", cause, 2);
        ton_max = 16'd3;
        pulse_on();
        tick(2);
        fb = 1'b1;
        tick();
        fb = 1'b0;
        check("R10 on-time over feedback gate", gate, 0);
        check("R10 on-time over feedback cause", cause, 1);
        ton_max = 16'd500;
        pulse_on();
        shrt = 1'b1; ilim = 1'b1; ssw_len = 8'd1;
        tick();
        shrt = 1'b0; ilim = 1'b0;
        check("R10 latch over ilim cause", cause, 3);
        check("R10 latch over ilim latched", latched, 1);
        do_reset();
        ssw_len = 8'd4;
        n = 0;
    endtask

    task automatic t_short();
        ssw_len = 8'd4;
        ton_max = 16'd500;
        pulse_on();
        shrt = 1'b1;
        tick(3);
        shrt = 1'b0;
        tick();
        check("R8 short pulse no latch", latched, 0);
        check("R8 short pulse gate stays", gate, 1);
        shrt = 1'b1;
        tick(3);
        check("R8 count restarted not yet latched", latched, 0);
        tick();
        shrt = 1'b0;
        check("R7 latched after full window", latched, 1);
        check("R7 gate low", gate, 0);
        check("R7 cause latch-off", cause, 3);
        on_req = 1'b1;
        tick(5);
        check("R9 request ignored while latched", gate, 0);
        check("R9 stays latched", latched, 1);
        on_req = 1'b0;
        do_reset();
        check("R9 reset clears latch", latched, 0);
        pulse_on();
        check("R9 turns on after reset", gate, 1);
        fb = 1'b1;
        tick();
        fb = 1'b0;
    endtask

    initial begin
        #1;
        t_reset();
        t_on_fb();
        t_ontime();
        t_ilim();
        t_priority();
        t_short();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule